// File: doc/BRIEF.md
# Display Core Clock Bring-Up Sequencer

This block steps a display engine's core clock domain through power-on and power-off. An init pulse turns off a reset-handshake enable that has no partner to answer it. It then raises the power-domain request for the clock PLL and looks at the PLL enable status. If the PLL is already running, the block finishes at once and reports the clock as already up. If not, it asks an external frequency-change engine for the top core frequency. It then powers the display data buffer through a request/state pair and checks the state after a fixed wait.

An uninit pulse runs the same work in reverse. It drops the buffer request and checks after the fixed wait that the buffer state has gone low. It then asks the frequency-change engine for the bypass frequency, which stops the PLL, and finally releases the power-domain request. The frequency-change engine and the power-domain logic sit outside the block. The engine is reached through a held request with a frequency code and a one-cycle done or error reply.

Top module: `dclk_bringup_seq`

## Requirements
- R1: After reset, `hs_en` is 1, and `pd_req`, `buf_req`, `freq_req`, `busy`, `done`, `err` and `already_up` are all 0.
- R2: Init drives `hs_en` to 0 before `pd_req` rises, so `pd_req` never rises while `hs_en` is 1.
- R3: If `pll_en` is 1 when init checks it, the sequence ends with `already_up`=1 and `err`=0. No frequency request is made and `buf_req` keeps its value.
- R4: If `pll_en` is 0, init raises `freq_req` with `freq_khz`=TOP_KHZ (624000 by default). The request is held until `freq_done` or `freq_err` is seen.
- R5: After `freq_done` on init, `buf_req` goes to 1. `done` pulses exactly CLK_PER_US×WAIT_US cycles after `buf_req` rises. `err` is 1 when `buf_state` is 0 at that sample.
- R6: A `freq_err` during init ends the sequence with `err`=1 and leaves `buf_req` unchanged.
- R7: Uninit clears `buf_req` and waits CLK_PER_US×WAIT_US cycles. It flags `err` if `buf_state` is still 1, then requests `freq_khz`=BYP_KHZ (19200 by default), then drops `pd_req` in the same cycle that `done` pulses. `hs_en` is left untouched, and a `freq_err` here sets `err` but the release still happens.
- R8: An init or uninit pulse that arrives while `busy` is 1 is ignored: it yields no extra `done` and does not change the running result. When both pulses arrive together while idle, init is taken.
- R9: `done` is a one-cycle pulse with `busy`=0. `busy` is 1 from the cycle after an accepted request until `done`. `err` and `already_up` hold their value until the next accepted request, which clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | One-cycle pulse to start power-on |
| uninit_req | input | 1 | One-cycle pulse to start power-off |
| pll_en | input | 1 | PLL enable status |
| freq_done | input | 1 | Frequency engine finished (one cycle) |
| freq_err | input | 1 | Frequency engine failed (one cycle) |
| buf_state | input | 1 | Data buffer power state |
| hs_en | output | 1 | Reset-handshake enable bit |
| pd_req | output | 1 | PLL power-domain request |
| freq_req | output | 1 | Frequency-change request, held |
| freq_khz | output | KHZ_W | Requested frequency in kHz |
| buf_req | output | 1 | Data buffer power request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (one cycle) |
| err | output | 1 | Last sequence saw an error |
| already_up | output | 1 | Last init found the PLL already running |

## Verification
The bench sets CLK_PER_US to 2, which makes the buffer wait 20 cycles. With a window that short, the bench can place a buffer model that answers in 5 cycles or in 30 cycles on both sides of the sample point. That reaches the timeout error on power-on and the stuck-state error on power-off within a short run. The frequency defaults are kept, so the bench sees the real 624000 and 19200 codes on `freq_khz`.

// File: rtl/dclk_pkg.sv
// Shared types for the display core clock bring-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dclk_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HSCLR,
        ST_PDREQ,
        ST_PLLCHK,
        ST_TOPFREQ,
        ST_BUFON,
        ST_BUFOFF,
        ST_BUFOFFW,
        ST_BYPFREQ,
        ST_PDREL
    } seq_state_e;
endpackage

// File: rtl/dclk_wait_timer.sv
// Fixed-length wait timer: a start pulse arms it, and expire goes high
// in the WAIT_CYC-th cycle after start.
// Assumes: start is never pulsed while the timer is running.
module dclk_wait_timer #(
    parameter int WAIT_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    logic [CW-1:0] cnt;
    logic          run;

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CW'(WAIT_CYC - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    // Expiry is the last counted cycle.
    always_comb expire = run && (cnt == '0);

    // R5: a window expires only once
    p_expire_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
    // R5: no restart while a window is open
    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run);
endmodule

// File: rtl/dclk_seq_fsm.sv
// Power-on / power-off step machine for the display core clock domain.
// Owns every output register. It relies on the frequency engine for
// PLL reprogramming and on an external timer for the buffer wait.
// Assumes: freq_done/freq_err are single-cycle replies to a held freq_req.
module dclk_seq_fsm
    import dclk_pkg::*;
#(
    parameter int TOP_KHZ = 624000,
    parameter int BYP_KHZ = 19200,
    parameter int KHZ_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             uninit_req,
    input  logic             pll_en,
    input  logic             freq_done,
    input  logic             freq_err,
    input  logic             buf_state,
    input  logic             tmr_exp,
    output logic             tmr_start,
    output logic             hs_en,
    output logic             pd_req,
    output logic             freq_req,
    output logic [KHZ_W-1:0] freq_khz,
    output logic             buf_req,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             already_up
);
    seq_state_e state;

    // Arm the buffer wait on a good top-frequency reply or on power-off entry.
    always_comb tmr_start = ((state == ST_TOPFREQ) && freq_done && !freq_err)
                            || (state == ST_BUFOFF);

    // Busy whenever a sequence step is pending.
    always_comb busy = (state != ST_IDLE);

    // Step sequencing and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            hs_en      <= 1'b1;
            pd_req     <= 1'b0;
            freq_req   <= 1'b0;
            freq_khz   <= '0;
            buf_req    <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            already_up <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (init_req) begin
                        state      <= ST_HSCLR;
                        err        <= 1'b0;
                        already_up <= 1'b0;
                    end else if (uninit_req) begin
                        state      <= ST_BUFOFF;
                        err        <= 1'b0;
                        already_up <= 1'b0;
                    end
                end
                ST_HSCLR: begin
                    hs_en <= 1'b0;
                    state <= ST_PDREQ;
                end
                ST_PDREQ: begin
                    pd_req <= 1'b1;
                    state  <= ST_PLLCHK;
                end
                ST_PLLCHK: begin
                    if (pll_en) begin
                        already_up <= 1'b1;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        freq_req <= 1'b1;
                        freq_khz <= KHZ_W'(TOP_KHZ);
                        state    <= ST_TOPFREQ;
                    end
                end
                ST_TOPFREQ: begin
                    if (freq_err) begin
                        freq_req <= 1'b0;
                        err      <= 1'b1;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (freq_done) begin
                        freq_req <= 1'b0;
                        buf_req  <= 1'b1;
                        state    <= ST_BUFON;
                    end
                end
                ST_BUFON: begin
                    if (tmr_exp) begin
                        if (!buf_state) err <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_BUFOFF: begin
                    buf_req <= 1'b0;
                    state   <= ST_BUFOFFW;
                end
                ST_BUFOFFW: begin
                    if (tmr_exp) begin
                        if (buf_state) err <= 1'b1;
                        freq_req <= 1'b1;
                        freq_khz <= KHZ_W'(BYP_KHZ);
                        state    <= ST_BYPFREQ;
                    end
                end
                ST_BYPFREQ: begin
                    if (freq_err || freq_done) begin
                        freq_req <= 1'b0;
                        if (freq_err) err <= 1'b1;
                        state <= ST_PDREL;
                    end
                end
                ST_PDREL: begin
                    pd_req <= 1'b0;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: power-domain request rises only once the handshake enable is off
    p_pd_after_hs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_req) |-> !hs_en);
    // R3: a running PLL skips the frequency step
    p_skip_freq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLLCHK && pll_en) |=> (!freq_req && already_up && done));
    // R4: the frequency request is held until a reply
    p_freq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_req && !freq_done && !freq_err) |=> freq_req);
    // R6: an engine error on power-on leaves the buffer alone
    p_freq_err_no_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TOPFREQ && freq_err) |=> ($stable(buf_req) && err && done));
    // R7: the domain is released only after buffer and frequency are done
    p_release_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_req) |-> (!buf_req && !freq_req && done));
    // R8: a request during a sequence does not cut it short
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (init_req || uninit_req)) |=> (busy || done));
    // R9: done is a single cycle and only while idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/dclk_bringup_seq.sv
// Top of the display core clock bring-up sequencer: joins the step machine
// to the buffer wait timer. The wait is CLK_PER_US x WAIT_US cycles.
// Assumes: clk runs at CLK_PER_US MHz.
module dclk_bringup_seq #(
    parameter int CLK_PER_US = 50,
    parameter int WAIT_US    = 10,
    parameter int TOP_KHZ    = 624000,
    parameter int BYP_KHZ    = 19200,
    parameter int KHZ_W      = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             uninit_req,
    input  logic             pll_en,
    input  logic             freq_done,
    input  logic             freq_err,
    input  logic             buf_state,
    output logic             hs_en,
    output logic             pd_req,
    output logic             freq_req,
    output logic [KHZ_W-1:0] freq_khz,
    output logic             buf_req,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             already_up
);
    localparam int WAIT_CYC = CLK_PER_US * WAIT_US;

    logic tmr_start;
    logic tmr_exp;

    dclk_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .expire (tmr_exp)
    );

    dclk_seq_fsm #(
        .TOP_KHZ (TOP_KHZ),
        .BYP_KHZ (BYP_KHZ),
        .KHZ_W   (KHZ_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_req   (init_req),
        .uninit_req (uninit_req),
        .pll_en     (pll_en),
        .freq_done  (freq_done),
        .freq_err   (freq_err),
        .buf_state  (buf_state),
        .tmr_exp    (tmr_exp),
        .tmr_start  (tmr_start),
        .hs_en      (hs_en),
        .pd_req     (pd_req),
        .freq_req   (freq_req),
        .freq_khz   (freq_khz),
        .buf_req    (buf_req),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .already_up (already_up)
    );
endmodule

// File: tb/dclk_bringup_seq_tb.sv
module dclk_bringup_seq_tb;
    localparam int CPU  = 2;
    localparam int WIN  = CPU * 10;
    localparam int TOP  = 624000;
    localparam int BYP  = 19200;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        init_req = 1'b0, uninit_req = 1'b0;
    logic        pll_en = 1'b0, freq_done = 1'b0, freq_err = 1'b0, buf_state = 1'b0;
    logic        hs_en, pd_req, freq_req, buf_req, busy, done, err, already_up;
    logic [19:0] freq_khz;

    dclk_bringup_seq #(.CLK_PER_US(CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .uninit_req(uninit_req),
        .pll_en(pll_en), .freq_done(freq_done), .freq_err(freq_err),
        .buf_state(buf_state), .hs_en(hs_en), .pd_req(pd_req),
        .freq_req(freq_req), .freq_khz(freq_khz), .buf_req(buf_req),
        .busy(busy), .done(done), .err(err), .already_up(already_up)
    );

    typedef struct {
        string tag;
        int    err, al, hs, pd, bf, khz, win;
    } exp_t;
    exp_t q[$];

    int n_chk = 0, n_fail = 0;
    bit f_err_mode = 1'b0;
    int blat = 5;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Frequency engine model: replies 3 cycles after a request; PLL follows.
    int fcnt = 0; bit fresp = 1'b0;
    always @(negedge clk) begin
        freq_done = 1'b0; freq_err = 1'b0;
        if (rst_n && freq_req === 1'b1 && !fresp) begin
            fcnt++;
            if (fcnt >= 3) begin
                fresp = 1'b1;
                if (f_err_mode) freq_err = 1'b1;
                else begin
                    freq_done = 1'b1;
                    pll_en = (int'(freq_khz) == TOP);
                end
            end
        end else if (freq_req !== 1'b1) begin
            fcnt = 0; fresp = 1'b0;
        end
    end

    // Buffer power model: state follows request after blat cycles.
    int bcnt = 0;
    always @(negedge clk) begin
        if (!rst_n) bcnt = 0;
        else if (buf_req !== buf_state) begin
            bcnt++;
            if (bcnt >= blat) begin buf_state = buf_req; bcnt = 0; end
        end else bcnt = 0;
    end

    // Monitor / scoreboard.
    int last_khz = 0, wcnt = 0;
    logic prev_buf = 1'b0, prev_pd = 1'b0, prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            if (freq_req) last_khz = int'(freq_khz);
            if (buf_req !== prev_buf) wcnt = 0; else wcnt++;
            prev_buf = buf_req;
            if (!prev_pd && pd_req) chk("R2 hs_en at pd_req rise", int'(hs_en), 0);
            prev_pd = pd_req;
            if (prev_done && done) chk("R9 done width", 1, 0);
            prev_done = done;
            if (done) begin
                chk("R9 busy at done", int'(busy), 0);
                if (q.size() == 0) chk("R8 unexpected done", 1, 0);
                else begin
                    e = q.pop_front();
                    chk({e.tag, " err"}, int'(err), e.err);
                    chk({e.tag, " already_up"}, int'(already_up), e.al);
                    chk({e.tag, " hs_en"}, int'(hs_en), e.hs);
                    chk({e.tag, " pd_req"}, int'(pd_req), e.pd);
                    chk({e.tag, " buf_req"}, int'(buf_req), e.bf);
                    chk({e.tag, " freq_khz"}, last_khz, e.khz);
                    if (e.win != 0) chk({e.tag, " wait window"}, wcnt, e.win);
                end
                last_khz = 0;
            end
        end
    end

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_seq(bit is_init, exp_t e);
        q.push_back(e);
        @(negedge clk);
        if (is_init) init_req = 1'b1; else uninit_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0; uninit_req = 1'b0;
        chk("R9 busy after accept", int'(busy), 1);
        chk("R9 err cleared on accept", int'(err), 0);
        wait_done();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 hs_en", int'(hs_en), 1);
        chk("R1 pd_req", int'(pd_req), 0);
        chk("R1 buf_req", int'(buf_req), 0);
        chk("R1 freq_req", int'(freq_req), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        chk("R1 already_up", int'(already_up), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_seq(1, '{"R4 R5 init", 0, 0, 0, 1, 1, TOP, WIN});
        run_seq(1, '{"R3 init pll up", 0, 1, 0, 1, 1, 0, 0});
        run_seq(0, '{"R7 uninit", 0, 0, 0, 0, 0, BYP, 0});
        f_err_mode = 1'b1;
        run_seq(1, '{"R6 init engine error", 1, 0, 0, 1, 0, TOP, 0});
        f_err_mode = 1'b0;
        run_seq(0, '{"R7 uninit after error", 0, 0, 0, 0, 0, BYP, 0});
        blat = 30;
        run_seq(1, '{"R5 buffer late", 1, 0, 0, 1, 1, TOP, WIN});
        repeat (40) @(negedge clk);
        run_seq(0, '{"R7 buffer stuck", 1, 0, 0, 0, 0, BYP, 0});
        repeat (40) @(negedge clk);
        blat = 5;

        // R8: requests while busy are ignored
        q.push_back('{"R8 busy ignore", 0, 0, 0, 1, 1, TOP, WIN});
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
        repeat (6) @(negedge clk);
        uninit_req = 1'b1; @(negedge clk); uninit_req = 1'b0;
        init_req = 1'b1;   @(negedge clk); init_req = 1'b0;
        wait_done();
        repeat (40) @(negedge clk);
        chk("R8 idle after ignored requests", int'(busy), 0);
        chk("R8 queue drained", q.size(), 0);

        run_seq(0, '{"R7 uninit again", 0, 0, 0, 0, 0, BYP, 0});

        // R8: simultaneous pulses while idle pick init
        q.push_back('{"R8 both pulses", 0, 0, 0, 1, 1, TOP, WIN});
        @(negedge clk); init_req = 1'b1; uninit_req = 1'b1;
        @(negedge clk); init_req = 1'b0; uninit_req = 1'b0;
        wait_done();
        chk("R8 all results seen", q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule